// File: doc/BRIEF.md
# I2C Master Address-Phase and Framing Sequencer

This block drives the byte-level side of an I2C master. It holds two command slots. Software writes the active slot, and it can also queue a follow-up command in a second slot. Each command carries a slave address of up to ten bits, a byte count and five flags: wide addressing, header-only, read direction, open with a START and close with a STOP. The sequencer turns each command into a series of bus operations for a bit-level driver: START or repeated START, the address bytes, the data bytes and STOP. It checks the slave acknowledge after every address byte.

With wide addressing, the first address byte is the 11110 header, followed by address bits 9:8 and the direction bit. A second byte then carries address bits 7:0. In header-only mode the second byte is left out and the header takes the commanded direction. A 10-bit read therefore takes two commands. The first is a write-direction command with no data and no STOP. The queued command is header-only, reads and ends with a STOP. Because the first command leaves the bus open, the second one opens with a repeated START.

The bus driver sees a held request with an operation code, a byte to send and the master acknowledge bit. It answers with a one-cycle done strobe, the slave acknowledge bit and the received byte.

Top module: `i2c_addr_seq`

## Requirements
- R1: With wide addressing off, the single address byte is {addr[6:0], read}. Address bits 9:7 have no effect on it.
- R2: With wide addressing on, the first address byte is 5'b11110, then addr[9:8], then the direction bit.
- R3: With wide addressing on and header-only off, the header goes out with direction 0, followed by a second byte equal to addr[7:0]. Each is an operation of code 3 (byte write) whose slave acknowledge is checked.
- R4: With header-only on, only the header byte is sent, carrying the commanded direction bit.
- R5: A command with the start flag issues op code 0 (START) while the bus is free. It issues op code 1 (repeated START) when the previous command ended without a STOP.
- R6: A command with the stop flag ends with op code 2 (STOP). A command without it ends with no STOP, and the bus stays held.
- R7: When a command without a stop flag finishes while a queued command is valid, the queued command moves into the active slot at once and runs without returning to idle, and nxt_valid drops.
- R8: A command with a byte count of zero completes right after its last address acknowledge, with no data operation.
- R9: Reads use op code 4. bd_mack is 0 (ACK) for every byte except the last one of a command with the stop flag, which gets 1 (NACK). Each received byte appears on rd_byte with a one-cycle rd_valid.
- R10: A slave NACK (bd_rx_nack=1 with bd_done) on any address byte aborts the command. It sets nack_flag, clears the queued command and issues STOP.
- R11: Each write data byte is taken from wr_byte. wr_take pulses once per accepted data byte.
- R12: After reset the block is idle: no request, busy, nxt_valid and nack_flag all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_addr | input | 10 | Slave address for the command being loaded |
| cmd_cnt | input | CNT_W | Data byte count |
| cmd_ten | input | 1 | Wide (10-bit) addressing |
| cmd_rsame | input | 1 | Header-only address phase |
| cmd_read | input | 1 | Read direction |
| cmd_start | input | 1 | Open with START / repeated START |
| cmd_stop | input | 1 | Close with STOP |
| cur_load | input | 1 | Write the command fields into the active slot |
| nxt_load | input | 1 | Write the command fields into the queued slot |
| wr_byte | input | 8 | Data byte to transmit |
| bd_done | input | 1 | Bus driver finished the requested operation |
| bd_rx_nack | input | 1 | Slave answered NACK to a written byte |
| bd_rdata | input | 8 | Byte received by the bus driver |
| bd_req | output | 1 | Operation request, held until bd_done |
| bd_op | output | 3 | 0 START, 1 repeated START, 2 STOP, 3 write, 4 read |
| bd_wbyte | output | 8 | Byte to write |
| bd_mack | output | 1 | Master acknowledge bit for a read (1 = NACK) |
| wr_take | output | 1 | wr_byte consumed |
| rd_byte | output | 8 | Last received data byte |
| rd_valid | output | 1 | rd_byte updated |
| cmd_done | output | 1 | Active command finished its address and data phases |
| nxt_valid | output | 1 | Queued slot is occupied |
| nack_flag | output | 1 | Last command aborted on an address NACK |
| busy | output | 1 | Sequencer not idle |

## Verification
The bench uses the default CNT_W of 8. Small counts (0 to 3) reach the zero-count path and the last-byte NACK without long runs. A driver model answers each request after a short delay and returns a rising byte sequence. This makes it possible to chain a no-STOP command into a queued header-only read and observe the repeated START. It also lets an address NACK be injected while a queued command is waiting.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

  localparam int AW = 10;

  typedef enum logic [2:0] {
    OP_START  = 3'd0,
    OP_RSTART = 3'd1,
    OP_STOP   = 3'd2,
    OP_WRITE  = 3'd3,
    OP_READ   = 3'd4
  } bus_op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LAUNCH, ST_COND, ST_ADDR1, ST_ADDR2, ST_DATA, ST_STOP
  } seq_st_e;

  typedef struct packed {
    logic [AW-1:0] addr;
    logic          ten;
    logic          rsame;
    logic          rd;
    logic          start;
    logic          stop;
  } cmd_hdr_t;

endpackage

// File: rtl/i2c_cmd_slots.sv
module i2c_cmd_slots
  import i2c_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cmd_hdr_t         in_hdr,
  input  logic [CNT_W-1:0] in_cnt,
  input  logic             cur_load,
  input  logic             nxt_load,
  input  logic             accept,
  input  logic             promote,
  input  logic             flush,
  output cmd_hdr_t         cur_hdr,
  output logic [CNT_W-1:0] cur_cnt,
  output logic             cur_pend,
  output logic             nxt_valid
);

  cmd_hdr_t         nxt_hdr;
  logic [CNT_W-1:0] nxt_cnt;
  cmd_hdr_t         cur_hdr_d, nxt_hdr_d;
  logic [CNT_W-1:0] cur_cnt_d, nxt_cnt_d;
  logic             cur_pend_d, nxt_valid_d;
  logic             cur_en, nxt_en;

  always_comb begin
    cur_en      = cur_load | promote;
    nxt_en      = nxt_load;
    cur_hdr_d   = promote ? nxt_hdr : in_hdr;
    cur_cnt_d   = promote ? nxt_cnt : in_cnt;
    nxt_hdr_d   = in_hdr;
    nxt_cnt_d   = in_cnt;
    cur_pend_d  = (cur_pend & ~accept) | cur_load;
    nxt_valid_d = (nxt_valid & ~promote & ~flush) | nxt_load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_hdr   <= '0;
      cur_cnt   <= '0;
      nxt_hdr   <= '0;
      nxt_cnt   <= '0;
      cur_pend  <= 1'b0;
      nxt_valid <= 1'b0;
    end else begin
      if (cur_en) begin
        cur_hdr <= cur_hdr_d;
        cur_cnt <= cur_cnt_d;
      end
      if (nxt_en) begin
        nxt_hdr <= nxt_hdr_d;
        nxt_cnt <= nxt_cnt_d;
      end
      cur_pend  <= cur_pend_d;
      nxt_valid <= nxt_valid_d;
    end
  end

  AST_PROMOTE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (promote && !nxt_load) |=> !nxt_valid); // R7
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !nxt_load) |=> !nxt_valid); // R10

endmodule

// File: rtl/i2c_addr_build.sv
module i2c_addr_build
  import i2c_seq_pkg::*;
(
  input  cmd_hdr_t   hdr,
  output logic [7:0] first_byte,
  output logic [7:0] second_byte,
  output logic       two_bytes
);

  logic hdr_dir;

  always_comb begin
    hdr_dir     = hdr.rsame ? hdr.rd : 1'b0;
    two_bytes   = hdr.ten & ~hdr.rsame;
    second_byte = hdr.addr[7:0];
    if (hdr.ten) first_byte = {5'b11110, hdr.addr[9:8], hdr_dir};
    else         first_byte = {hdr.addr[6:0], hdr.rd};
  end

endmodule

// File: rtl/i2c_frame_fsm.sv
module i2c_frame_fsm
  import i2c_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cmd_hdr_t         cur_hdr,
  input  logic [CNT_W-1:0] cur_cnt,
  input  logic             cur_pend,
  input  logic             nxt_valid,
  input  logic             clr_nack,
  input  logic [7:0]       first_byte,
  input  logic [7:0]       second_byte,
  input  logic             two_bytes,
  input  logic [7:0]       wr_byte,
  input  logic             bd_done,
  input  logic             bd_rx_nack,
  input  logic [7:0]       bd_rdata,
  output logic             accept,
  output logic             promote,
  output logic             flush,
  output logic             bd_req,
  output bus_op_e          bd_op,
  output logic [7:0]       bd_wbyte,
  output logic             bd_mack,
  output logic             wr_take,
  output logic [7:0]       rd_byte,
  output logic             rd_valid,
  output logic             cmd_done,
  output logic             nack_flag,
  output logic             busy
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  seq_st_e          st, st_d;
  logic [CNT_W-1:0] rem, rem_d;
  logic             held, held_d;
  logic             nack_d;
  logic [7:0]       rdb_d;
  logic             rdv_d;
  logic             fin, post, abort_c;
  logic             cnt_zero;

  always_comb begin
    st_d     = st;
    rem_d    = rem;
    held_d   = held;
    nack_d   = nack_flag;
    rdb_d    = rd_byte;
    rdv_d    = 1'b0;
    accept   = 1'b0;
    promote  = 1'b0;
    flush    = 1'b0;
    fin      = 1'b0;
    post     = 1'b0;
    abort_c  = 1'b0;
    bd_req   = 1'b0;
    bd_op    = OP_STOP;
    bd_wbyte = 8'h00;
    bd_mack  = 1'b0;
    wr_take  = 1'b0;
    cnt_zero = (cur_cnt == '0);
    if (clr_nack) nack_d = 1'b0;

    case (st)
      ST_IDLE: begin
        if (cur_pend) begin
          accept = 1'b1;
          st_d   = ST_LAUNCH;
        end
      end
      ST_LAUNCH: begin
        if (cur_hdr.start) st_d = ST_COND;
        else               post = 1'b1;
      end
      ST_COND: begin
        bd_req = 1'b1;
        bd_op  = held ? OP_RSTART : OP_START;
        if (bd_done) begin
          held_d = 1'b1;
          st_d   = ST_ADDR1;
        end
      end
      ST_ADDR1: begin
        bd_req   = 1'b1;
        bd_op    = OP_WRITE;
        bd_wbyte = first_byte;
        if (bd_done) begin
          if (bd_rx_nack)     abort_c = 1'b1;
          else if (two_bytes) st_d = ST_ADDR2;
          else                post = 1'b1;
        end
      end
      ST_ADDR2: begin
        bd_req   = 1'b1;
        bd_op    = OP_WRITE;
        bd_wbyte = second_byte;
        if (bd_done) begin
          if (bd_rx_nack) abort_c = 1'b1;
          else            post = 1'b1;
        end
      end
      ST_DATA: begin
        bd_req   = 1'b1;
        bd_op    = cur_hdr.rd ? OP_READ : OP_WRITE;
        bd_wbyte = cur_hdr.rd ? 8'h00 : wr_byte;
        bd_mack  = cur_hdr.rd & cur_hdr.stop & (rem == ONE);
        if (bd_done) begin
          rem_d = rem - ONE;
          if (cur_hdr.rd) begin
            rdv_d = 1'b1;
            rdb_d = bd_rdata;
          end else begin
            wr_take = 1'b1;
          end
          if (rem == ONE) fin = 1'b1;
        end
      end
      ST_STOP: begin
        bd_req = 1'b1;
        bd_op  = OP_STOP;
        if (bd_done) begin
          held_d = 1'b0;
          st_d   = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase

    if (post) begin
      if (cnt_zero) fin = 1'b1;
      else begin
        rem_d = cur_cnt;
        st_d  = ST_DATA;
      end
    end

    if (abort_c) begin
      nack_d = 1'b1;
      flush  = 1'b1;
      st_d   = ST_STOP;
    end

    if (fin) begin
      if (cur_hdr.stop) st_d = ST_STOP;
      else if (nxt_valid) begin
        promote = 1'b1;
        st_d    = ST_LAUNCH;
      end else st_d = ST_IDLE;
    end

    cmd_done = fin;
    busy     = (st != ST_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      rem       <= '0;
      held      <= 1'b0;
      nack_flag <= 1'b0;
      rd_byte   <= 8'h00;
      rd_valid  <= 1'b0;
    end else begin
      st        <= st_d;
      rem       <= rem_d;
      held      <= held_d;
      nack_flag <= nack_d;
      rd_byte   <= rdb_d;
      rd_valid  <= rdv_d;
    end
  end

  AST_HDR_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ADDR1 && cur_hdr.ten) |-> bd_wbyte[7:3] == 5'b11110); // R2
  AST_ABORT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_ADDR1 || st == ST_ADDR2) && bd_done && bd_rx_nack)
      |=> (bd_req && bd_op == OP_STOP && nack_flag)); // R10
  AST_DATA_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DATA) |-> rem != '0); // R8
  AST_LAST_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DATA && bd_done && bd_mack) |=> st != ST_DATA); // R9

endmodule

// File: rtl/i2c_addr_seq.sv
module i2c_addr_seq
  import i2c_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [9:0]       cmd_addr,
  input  logic [CNT_W-1:0] cmd_cnt,
  input  logic             cmd_ten,
  input  logic             cmd_rsame,
  input  logic             cmd_read,
  input  logic             cmd_start,
  input  logic             cmd_stop,
  input  logic             cur_load,
  input  logic             nxt_load,
  input  logic [7:0]       wr_byte,
  input  logic             bd_done,
  input  logic             bd_rx_nack,
  input  logic [7:0]       bd_rdata,
  output logic             bd_req,
  output logic [2:0]       bd_op,
  output logic [7:0]       bd_wbyte,
  output logic             bd_mack,
  output logic             wr_take,
  output logic [7:0]       rd_byte,
  output logic             rd_valid,
  output logic             cmd_done,
  output logic             nxt_valid,
  output logic             nack_flag,
  output logic             busy
);

  cmd_hdr_t         in_hdr, cur_hdr;
  logic [CNT_W-1:0] cur_cnt;
  logic             cur_pend, accept, promote, flush;
  logic [7:0]       first_byte, second_byte;
  logic             two_bytes;
  bus_op_e          op_e;

  always_comb begin
    in_hdr.addr  = cmd_addr;
    in_hdr.ten   = cmd_ten;
    in_hdr.rsame = cmd_rsame;
    in_hdr.rd    = cmd_read;
    in_hdr.start = cmd_start;
    in_hdr.stop  = cmd_stop;
    bd_op        = op_e;
  end

  i2c_cmd_slots #(.CNT_W(CNT_W)) u_slots (
    .clk(clk), .rst_n(rst_n), .in_hdr(in_hdr), .in_cnt(cmd_cnt),
    .cur_load(cur_load), .nxt_load(nxt_load), .accept(accept),
    .promote(promote), .flush(flush), .cur_hdr(cur_hdr), .cur_cnt(cur_cnt),
    .cur_pend(cur_pend), .nxt_valid(nxt_valid)
  );

  i2c_addr_build u_build (
    .hdr(cur_hdr), .first_byte(first_byte), .second_byte(second_byte),
    .two_bytes(two_bytes)
  );

  i2c_frame_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .cur_hdr(cur_hdr), .cur_cnt(cur_cnt),
    .cur_pend(cur_pend), .nxt_valid(nxt_valid), .clr_nack(cur_load),
    .first_byte(first_byte), .second_byte(second_byte), .two_bytes(two_bytes),
    .wr_byte(wr_byte), .bd_done(bd_done), .bd_rx_nack(bd_rx_nack),
    .bd_rdata(bd_rdata), .accept(accept), .promote(promote), .flush(flush),
    .bd_req(bd_req), .bd_op(op_e), .bd_wbyte(bd_wbyte), .bd_mack(bd_mack),
    .wr_take(wr_take), .rd_byte(rd_byte), .rd_valid(rd_valid),
    .cmd_done(cmd_done), .nack_flag(nack_flag), .busy(busy)
  );

endmodule

// File: tb/tb_i2c_addr_seq.sv
module tb_i2c_addr_seq;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;

  typedef struct {
    logic [2:0] op;
    logic [7:0] data;
    logic       mack;
  } item_t;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [9:0]       cmd_addr = '0;
  logic [CNT_W-1:0] cmd_cnt = '0;
  logic             cmd_ten = 1'b0, cmd_rsame = 1'b0, cmd_read = 1'b0;
  logic             cmd_start = 1'b0, cmd_stop = 1'b0;
  logic             cur_load = 1'b0, nxt_load = 1'b0;
  logic [7:0]       wr_byte = 8'hC3;
  logic             bd_done = 1'b0, bd_rx_nack = 1'b0;
  logic [7:0]       bd_rdata = 8'h00;
  logic             bd_req, bd_mack, wr_take, rd_valid, cmd_done;
  logic             nxt_valid, nack_flag, busy;
  logic [2:0]       bd_op;
  logic [7:0]       bd_wbyte, rd_byte;

  int    checks = 0, errors = 0;
  item_t exp_q[$];
  logic  nack_addr = 1'b0;
  int    rd_seq = 0;
  int    wr_takes = 0, rd_count = 0;
  logic [7:0] rd_last = 8'h00;
  bit    finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_addr_seq #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_addr(cmd_addr), .cmd_cnt(cmd_cnt),
    .cmd_ten(cmd_ten), .cmd_rsame(cmd_rsame), .cmd_read(cmd_read),
    .cmd_start(cmd_start), .cmd_stop(cmd_stop), .cur_load(cur_load),
    .nxt_load(nxt_load), .wr_byte(wr_byte), .bd_done(bd_done),
    .bd_rx_nack(bd_rx_nack), .bd_rdata(bd_rdata), .bd_req(bd_req),
    .bd_op(bd_op), .bd_wbyte(bd_wbyte), .bd_mack(bd_mack), .wr_take(wr_take),
    .rd_byte(rd_byte), .rd_valid(rd_valid), .cmd_done(cmd_done),
    .nxt_valid(nxt_valid), .nack_flag(nack_flag), .busy(busy)
  );

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, actual, expected);
    end
  endtask

  task automatic push(logic [2:0] op, logic [7:0] data, logic mack);
    item_t it;
    it.op = op; it.data = data; it.mack = mack;
    exp_q.push_back(it);
  endtask

  task automatic load_cmd(bit to_next, logic [9:0] a, int n, bit ten, bit rs,
                          bit rd, bit st, bit sp);
    @(negedge clk);
    cmd_addr = a; cmd_cnt = CNT_W'(n); cmd_ten = ten; cmd_rsame = rs;
    cmd_read = rd; cmd_start = st; cmd_stop = sp;
    if (to_next) nxt_load = 1'b1; else cur_load = 1'b1;
    @(negedge clk);
    cur_load = 1'b0; nxt_load = 1'b0;
  endtask

  task automatic wait_quiet();
    int n = 0;
    while ((busy || exp_q.size() != 0) && n < 2000) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
  endtask

  // Monitor and bus driver model: pops expected items as requests appear
  initial begin
    item_t e;
    forever begin
      @(negedge clk);
      if (rst_n && bd_req) begin
        if (exp_q.size() == 0) begin
          check("unexpected request op", int'(bd_op), 7);
        end else begin
          e = exp_q.pop_front();
          check("R1-style op sequence (R5 R6 R8)", int'(bd_op), int'(e.op));
          if (e.op == 3'd3) check("R1 R2 R3 R4 R11 byte", int'(bd_wbyte), int'(e.data));
          if (e.op == 3'd4) check("R9 master ack bit", int'(bd_mack), int'(e.mack));
        end
        repeat (2) @(negedge clk);
        bd_rx_nack = 1'b0;
        if (bd_op == 3'd3 && nack_addr) begin
          bd_rx_nack = 1'b1;
          nack_addr  = 1'b0;
        end
        if (bd_op == 3'd4) begin
          bd_rdata = 8'(8'h50 + rd_seq);
          rd_seq++;
        end
        bd_done = 1'b1;
        @(negedge clk);
        bd_done = 1'b0;
        bd_rx_nack = 1'b0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && wr_take) wr_takes++;
    if (rst_n && rd_valid) begin
      rd_count++;
      rd_last = rd_byte;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 bd_req", int'(bd_req), 0);
    check("R12 busy", int'(busy), 0);
    check("R12 nxt_valid", int'(nxt_valid), 0);
    check("R12 nack_flag", int'(nack_flag), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 R11: 7-bit write, upper bits ignored
    push(3'd0, 8'h00, 1'b0);
    push(3'd3, 8'h4A, 1'b0);
    push(3'd3, 8'hC3, 1'b0);
    push(3'd3, 8'hC3, 1'b0);
    push(3'd2, 8'h00, 1'b0);
    wr_takes = 0;
    load_cmd(0, 10'h3A5, 2, 0, 0, 0, 1, 1);
    wait_quiet();
    check("R11 wr_take pulses", wr_takes, 2);
    check("R6 bus released", int'(busy), 0);

    // R2 R3: 10-bit write
    push(3'd0, 8'h00, 1'b0);
    push(3'd3, 8'hF4, 1'b0);
    push(3'd3, 8'hB7, 1'b0);
    push(3'd3, 8'hC3, 1'b0);
    push(3'd2, 8'h00, 1'b0);
    load_cmd(0, 10'h2B7, 1, 1, 0, 0, 1, 1);
    wait_quiet();

    // R4 R5 R7 R8 R9: 10-bit read via two chained commands
    push(3'd0, 8'h00, 1'b0);
    push(3'd3, 8'hF2, 1'b0);
    push(3'd3, 8'hC9, 1'b0);
    push(3'd1, 8'h00, 1'b0);
    push(3'd3, 8'hF3, 1'b0);
    push(3'd4, 8'h00, 1'b0);
    push(3'd4, 8'h00, 1'b0);
    push(3'd4, 8'h00, 1'b1);
    push(3'd2, 8'h00, 1'b0);
    rd_seq = 0; rd_count = 0;
    load_cmd(0, 10'h1C9, 0, 1, 0, 0, 1, 0);
    load_cmd(1, 10'h1C9, 3, 1, 1, 1, 1, 1);
    check("R7 queued slot occupied", int'(nxt_valid), 1);
    wait_quiet();
    check("R7 nxt_valid freed", int'(nxt_valid), 0);
    check("R9 read count", rd_count, 3);
    check("R9 last read byte", int'(rd_last), 8'h52);

    // R10: NACK on address aborts, queue discarded
    nack_addr = 1'b1;
    push(3'd0, 8'h00, 1'b0);
    push(3'd3, 8'h22, 1'b0);
    push(3'd2, 8'h00, 1'b0);
    load_cmd(0, 10'h011, 2, 0, 0, 0, 1, 1);
    load_cmd(1, 10'h033, 1, 0, 0, 0, 1, 1);
    wait_quiet();
    check("R10 nack_flag", int'(nack_flag), 1);
    check("R10 queue cleared", int'(nxt_valid), 0);
    check("R10 idle", int'(busy), 0);

    // R5 R6 R8 R9: no-STOP read holds bus, later command uses repeated START
    push(3'd0, 8'h00, 1'b0);
    push(3'd3, 8'h0B, 1'b0);
    push(3'd4, 8'h00, 1'b0);
    load_cmd(0, 10'h005, 1, 0, 0, 1, 1, 0);
    wait_quiet();
    check("R6 no STOP left pending", exp_q.size(), 0);
    check("R10 nack cleared by load", int'(nack_flag), 0);
    push(3'd1, 8'h00, 1'b0);
    push(3'd3, 8'h0A, 1'b0);
    push(3'd2, 8'h00, 1'b0);
    wr_takes = 0;
    load_cmd(0, 10'h005, 0, 0, 0, 0, 1, 1);
    wait_quiet();
    check("R8 no data on zero count", wr_takes, 0);
    check("R6 all items seen", exp_q.size(), 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule